// File: doc/BRIEF.md
# Bit Clock Recovery Loop

This block regenerates a receive bit clock from a stream of already-sliced data. A phase counter runs at sixteen samples per bit. Each data transition is compared against the point where the loop expects bit boundaries to fall, and the counter is pulled toward that point. The block drives two outputs from the counter. One is a single-cycle strobe at the centre of each bit, where downstream logic latches the data. The other is a square-wave receive clock.

How hard the loop pulls depends on its bandwidth mode. Raising `acq_req` at the start of a preamble puts the loop in a wide acquire mode. After thirty bits it moves to a medium mode. With `acq_req` low the loop sits in a narrow tracking mode. Driving `hold_n` low while `acq_req` is low freezes phase correction, for example during a fade. The clock outputs keep running at the phase they had, so tracking picks up again when `hold_n` returns high, with no reset.

Top module: `bitclk_dpll`

## Requirements

The terms below are used by several requirements.
- The phase is 0 in every cycle where `bit_strobe` is high.
- The phase rises by one per cycle, modulo 16.
- A transition is seen in a cycle when `data_in` differs from its value in the cycle before.
- When a transition is seen at phase p, the error is e = p - 8, with e in the range -8 to +7.
- In the next cycle the phase becomes (p + 1 - c) mod 16, where the correction c depends on the mode.
- With no transition, c = 0.
- `bw_mode` encodes the mode as 0 = acquire, 1 = medium, 2 = narrow.

The requirements:
- R1: During reset and in the first cycle after it, `bit_strobe` is 0, `rx_clk` is 0 and `bw_mode` is 2.
- R2: With no transitions, `bit_strobe` pulses for one cycle every 16 cycles. `rx_clk` is high for the 8 cycles at phases 0 to 7, which include the strobe cycle, and low for the other 8.
- R3: In acquire mode, c = e. Any transition therefore gives phase 9 in the next cycle.
- R4: In medium mode, c = e/4 rounded toward zero, with c forced to +1 or -1 (following the sign of e) when e is nonzero but the quotient is 0. For example, e = -8 gives c = -2 and e = 7 gives c = +1.
- R5: In narrow mode, c is +1 when e > 0, -1 when e < 0 and 0 when e = 0.
- R6: The loop follows a fixed sequence of modes:
  - `bw_mode` is 0 from the cycle in which `acq_req` rises.
  - It becomes 1 in the cycle after the 30th strobe that follows the rise cycle.
  - It is 2 in every cycle with `acq_req` low.
- R7: Every new rising edge of `acq_req` restarts the 30-bit acquire count, even when the loop is already in medium mode.
- R8: When `acq_req` and `hold_n` are both low, c = 0 for every transition. `bit_strobe` keeps pulsing every 16 cycles.
- R9: While `acq_req` is high, `hold_n` has no effect on the correction.
- R10: After a hold of any length (250 bits is tested), raising `hold_n` with `acq_req` low restores narrow correction at the very next transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, 16 cycles per bit |
| rst_n | input | 1 | Active-low synchronous reset |
| data_in | input | 1 | Sliced receive data |
| acq_req | input | 1 | High to acquire, then medium mode; low for narrow tracking |
| hold_n | input | 1 | Low freezes phase correction while `acq_req` is low |
| bit_strobe | output | 1 | One-cycle pulse at the centre of each bit |
| rx_clk | output | 1 | Recovered clock, high during phases 0 to 7 |
| bw_mode | output | 2 | Current mode: 0 acquire, 1 medium, 2 narrow |

## Verification
The bench builds the block with its default parameters:
- `OSR` = 16
- `ACQ_BITS` = 30
- `MED_SHIFT` = 2
- `SYNC_STAGES` = 0

With no input synchroniser, a transition driven in a chosen cycle acts on the phase at the very next edge. The correction can therefore be read exactly from the distance to the next strobe. The vector table covers these error values:
- e = -8, the most negative error;
- e = +7, the most positive error;
- e = 0;
- values that round to zero in medium mode.

The 30-bit count is short enough that the exact acquire-to-medium boundary can be checked. So can a 250-bit hold.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

   typedef enum logic [1:0] {
      BW_ACQ = 2'd0,
      BW_MED = 2'd1,
      BW_NAR = 2'd2
   } bw_mode_e;

endpackage

// File: rtl/dpll_edge_det.sv
module dpll_edge_det #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic data_in,
   output logic edge_seen
);

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         logic data_q;
         always_ff @(posedge clk) begin
            if (!rst_n) data_q <= 1'b0;
            else        data_q <= data_in;
         end
         assign edge_seen = data_in ^ data_q;
      end else begin : g_synced
         logic [SYNC_STAGES:0] sr_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sr_q <= '0;
            else        sr_q <= {sr_q[SYNC_STAGES-1:0], data_in};
         end
         assign edge_seen = sr_q[SYNC_STAGES] ^ sr_q[SYNC_STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/dpll_mode_seq.sv
module dpll_mode_seq
   import dpll_pkg::*;
#(
   parameter int ACQ_BITS = 30
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     acq_req,
   input  logic     strobe,
   output bw_mode_e bw_mode
);

   localparam int CNT_W = $clog2(ACQ_BITS + 1);
   localparam logic [CNT_W-1:0] CNT_END = CNT_W'(ACQ_BITS);

   logic             acq_q;
   logic [CNT_W-1:0] bits_q;
   logic             acq_rise;

   assign acq_rise = acq_req & ~acq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acq_q  <= 1'b0;
         bits_q <= CNT_END;
      end else begin
         acq_q <= acq_req;
         if (acq_rise)
            bits_q <= '0;
         else if (acq_req && strobe && (bits_q < CNT_END))
            bits_q <= bits_q + 1'b1;
      end
   end

   always_comb begin
      if (!acq_req)
         bw_mode = BW_NAR;
      else if (acq_rise || (bits_q < CNT_END))
         bw_mode = BW_ACQ;
      else
         bw_mode = BW_MED;
   end

endmodule

// File: rtl/dpll_loop_filter.sv
module dpll_loop_filter
   import dpll_pkg::*;
#(
   parameter int PHASE_W   = 4,
   parameter int MED_SHIFT = 2
) (
   input  logic [PHASE_W-1:0] phase,
   input  logic               edge_seen,
   input  bw_mode_e           bw_mode,
   input  logic               acq_req,
   input  logic               hold_n,
   output logic [PHASE_W:0]   corr
);

   localparam int EW = PHASE_W + 1;
   localparam logic [EW-1:0] HALF = EW'(2 ** (PHASE_W - 1));

   logic [EW-1:0] err;
   logic          neg;
   logic [EW-1:0] mag;
   logic [EW-1:0] med_mag;
   logic [EW-1:0] med_corr;
   logic [EW-1:0] nar_corr;
   logic          freeze;

   assign err    = {1'b0, phase} - HALF;
   assign neg    = err[EW-1];
   assign mag    = neg ? (~err + 1'b1) : err;
   assign freeze = ~hold_n & ~acq_req;

   generate
      if (MED_SHIFT == 0) begin : g_med_full
         assign med_mag = mag;
      end else begin : g_med_shift
         logic [EW-1:0] shifted;
         assign shifted = mag >> MED_SHIFT;
         assign med_mag = ((shifted == '0) && (mag != '0)) ? EW'(1) : shifted;
      end
   endgenerate

   assign med_corr = neg ? (~med_mag + 1'b1) : med_mag;
   assign nar_corr = (mag == '0) ? '0 : (neg ? '1 : EW'(1));

   always_comb begin
      corr = '0;
      if (edge_seen && !freeze) begin
         case (bw_mode)
            BW_ACQ:  corr = err;
            BW_MED:  corr = med_corr;
            default: corr = nar_corr;
         endcase
      end
   end

endmodule

// File: rtl/dpll_phase_acc.sv
module dpll_phase_acc #(
   parameter int PHASE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PHASE_W:0]   corr,
   output logic [PHASE_W-1:0] phase,
   output logic               strobe,
   output logic               rx_clk
);

   localparam int NW = PHASE_W + 2;
   localparam logic [PHASE_W-1:0] PH_RESET = PHASE_W'(2 ** (PHASE_W - 1));

   logic [PHASE_W-1:0] phase_q;
   logic [NW-1:0]      nxt;

   assign nxt = {2'b00, phase_q} + NW'(1) - {corr[PHASE_W], corr};

   always_ff @(posedge clk) begin
      if (!rst_n) phase_q <= PH_RESET;
      else        phase_q <= nxt[PHASE_W-1:0];
   end

   assign phase  = phase_q;
   assign strobe = (phase_q == '0);
   assign rx_clk = ~phase_q[PHASE_W-1];

endmodule

// File: rtl/bitclk_dpll.sv
module bitclk_dpll
   import dpll_pkg::*;
#(
   parameter int OSR         = 16,
   parameter int ACQ_BITS    = 30,
   parameter int MED_SHIFT   = 2,
   parameter int SYNC_STAGES = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       data_in,
   input  logic       acq_req,
   input  logic       hold_n,
   output logic       bit_strobe,
   output logic       rx_clk,
   output logic [1:0] bw_mode
);

   localparam int PHASE_W = $clog2(OSR);

   generate
      if ((OSR < 4) || ((1 << PHASE_W) != OSR)) begin : g_bad_osr
         $error("OSR must be a power of two of at least 4");
      end
      if (ACQ_BITS < 1) begin : g_bad_acq
         $error("ACQ_BITS must be at least 1");
      end
      if ((MED_SHIFT < 0) || (MED_SHIFT >= PHASE_W)) begin : g_bad_shift
         $error("MED_SHIFT must lie below the phase width");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic               edge_seen;
   logic [PHASE_W-1:0] phase;
   logic [PHASE_W:0]   corr;
   logic               strobe;
   bw_mode_e           mode;

   dpll_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .data_in   (data_in),
      .edge_seen (edge_seen)
   );

   dpll_mode_seq #(.ACQ_BITS(ACQ_BITS)) u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .acq_req (acq_req),
      .strobe  (strobe),
      .bw_mode (mode)
   );

   dpll_loop_filter #(.PHASE_W(PHASE_W), .MED_SHIFT(MED_SHIFT)) u_filt (
      .phase     (phase),
      .edge_seen (edge_seen),
      .bw_mode   (mode),
      .acq_req   (acq_req),
      .hold_n    (hold_n),
      .corr      (corr)
   );

   dpll_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .corr   (corr),
      .phase  (phase),
      .strobe (strobe),
      .rx_clk (rx_clk)
   );

   assign bit_strobe = strobe;
   assign bw_mode    = mode;

endmodule

// File: rtl/bitclk_dpll_chk.sv
module bitclk_dpll_chk #(
   parameter int OSR = 16
) (
   input logic       clk,
   input logic       rst_n,
   input logic       acq_req,
   input logic       hold_n,
   input logic       bit_strobe,
   input logic       rx_clk,
   input logic [1:0] bw_mode
);

   localparam int SW = $clog2(OSR) + 1;

   logic          hold_now;
   logic          run_ok_q;
   logic [SW-1:0] since_q;

   assign hold_now = ~acq_req & ~hold_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_ok_q <= 1'b0;
         since_q  <= '0;
      end else begin
         run_ok_q <= hold_now & (bit_strobe | run_ok_q);
         if (bit_strobe)
            since_q <= '0;
         else if (since_q != '1)
            since_q <= since_q + 1'b1;
      end
   end

   assert_strobe_in_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bit_strobe |-> rx_clk);

   assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bit_strobe |=> !bit_strobe);

   assert_narrow_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !acq_req |-> (bw_mode == 2'd2));

   assert_mode_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bw_mode != 2'd3);

   assert_acq_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_req && !$past(acq_req)) |-> (bw_mode == 2'd0));

   assert_med_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_req && $past(acq_req) && ($past(bw_mode) == 2'd1)) |-> (bw_mode == 2'd1));

   assert_hold_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_now && run_ok_q) |-> (bit_strobe == (since_q == SW'(OSR - 1))));

endmodule

bind bitclk_dpll bitclk_dpll_chk #(.OSR(OSR)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .acq_req    (acq_req),
   .hold_n     (hold_n),
   .bit_strobe (bit_strobe),
   .rx_clk     (rx_clk),
   .bw_mode    (bw_mode)
);

// File: tb/bitclk_dpll_tb_top.sv
`timescale 1ns/1ps
module bitclk_dpll_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       data_in = 1'b0;
   logic       acq_req = 1'b0;
   logic       hold_n = 1'b1;
   logic       bit_strobe;
   logic       rx_clk;
   logic [1:0] bw_mode;

   int n_checks = 0;
   int n_fails  = 0;

   always #2 clk = ~clk;

   bitclk_dpll dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .data_in    (data_in),
      .acq_req    (acq_req),
      .hold_n     (hold_n),
      .bit_strobe (bit_strobe),
      .rx_clk     (rx_clk),
      .bw_mode    (bw_mode)
   );

   // mode codes: 0 narrow, 1 medium, 2 acquire, 3 hold, 4 acquire with hold_n low
   // packed as {mode[10:8], phase p[7:4], expected next phase n[3:0]}
   localparam int NV = 13;
   localparam logic [10:0] VEC [NV] = '{
      {3'd2, 4'd3,  4'd9},
      {3'd2, 4'd12, 4'd9},
      {3'd2, 4'd0,  4'd9},
      {3'd1, 4'd15, 4'd15},
      {3'd1, 4'd0,  4'd3},
      {3'd1, 4'd5,  4'd7},
      {3'd1, 4'd13, 4'd13},
      {3'd0, 4'd2,  4'd4},
      {3'd0, 4'd14, 4'd14},
      {3'd0, 4'd8,  4'd9},
      {3'd3, 4'd3,  4'd4},
      {3'd3, 4'd12, 4'd13},
      {3'd4, 4'd4,  4'd9}
   };

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic string mode_tag(input int m);
      case (m)
         0: return "R5 narrow";
         1: return "R4 medium";
         2: return "R3 acquire";
         3: return "R8 hold";
         default: return "R9 hold ignored";
      endcase
   endfunction

   task automatic wait_strobe();
      do @(negedge clk); while (!bit_strobe);
   endtask

   task automatic restart_acq();
      acq_req = 1'b0;
      @(negedge clk);
      acq_req = 1'b1;
   endtask

   task automatic setup_mode(input int m);
      case (m)
         0: begin acq_req = 1'b0; hold_n = 1'b1; end
         1: begin hold_n = 1'b1; restart_acq(); repeat (31) wait_strobe(); end
         2: begin hold_n = 1'b1; restart_acq(); end
         3: begin acq_req = 1'b0; hold_n = 1'b0; end
         default: begin hold_n = 1'b0; restart_acq(); end
      endcase
   endtask

   // toggle data at phase p and check distance to the next strobe
   task automatic measure(input string tag, input int p, input int n);
      int d;
      int exp_d;
      wait_strobe();
      repeat (p) @(negedge clk);
      data_in = ~data_in;
      d = 0;
      do begin
         @(negedge clk);
         d++;
      end while (!bit_strobe && d < 40);
      exp_d = 1 + ((16 - n) % 16);
      check($sformatf("%s p=%0d strobe distance", tag, p), d, exp_d);
   endtask

   initial begin : watchdog
      #(4 * 150000);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin : main
      int cnt;
      int hi;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 strobe in reset", int'(bit_strobe), 0);
      check("R1 rx_clk in reset", int'(rx_clk), 0);
      check("R1 mode in reset", int'(bw_mode), 2);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 strobe after reset", int'(bit_strobe), 0);
      check("R1 mode after reset", int'(bw_mode), 2);

      // R2 free-running period and duty
      wait_strobe();
      check("R2 rx_clk in strobe cycle", int'(rx_clk), 1);
      cnt = 0;
      hi = 1;
      for (int i = 0; i < 15; i++) begin
         @(negedge clk);
         if (bit_strobe) cnt++;
         if (rx_clk) hi++;
      end
      @(negedge clk);
      check("R2 no extra strobe", cnt, 0);
      check("R2 high cycles per bit", hi, 8);
      check("R2 strobe after 16 cycles", int'(bit_strobe), 1);

      // vector table
      for (int v = 0; v < NV; v++) begin
         int m;
         m = int'(VEC[v][10:8]);
         setup_mode(m);
         measure(mode_tag(m), int'(VEC[v][7:4]), int'(VEC[v][3:0]));
      end
      hold_n = 1'b1;

      // R6 mode sequence boundary
      acq_req = 1'b0;
      wait_strobe();
      @(negedge clk);
      acq_req = 1'b1;
      #1;
      check("R6 acquire on rise", int'(bw_mode), 0);
      repeat (29) wait_strobe();
      @(negedge clk);
      check("R6 still acquire after 29 bits", int'(bw_mode), 0);
      wait_strobe();
      @(negedge clk);
      check("R6 medium after 30 bits", int'(bw_mode), 1);

      // R7 restart while in medium
      restart_acq();
      #1;
      check("R7 acquire after new rise", int'(bw_mode), 0);
      repeat (10) wait_strobe();
      @(negedge clk);
      check("R7 count restarted", int'(bw_mode), 0);
      acq_req = 1'b0;
      #1;
      check("R6 narrow when request low", int'(bw_mode), 2);

      // R8 / R10 long hold then resume
      hold_n = 1'b0;
      wait_strobe();
      cnt = 0;
      for (int i = 0; i < 250 * 16; i++) begin
         @(negedge clk);
         if (bit_strobe) cnt++;
      end
      check("R8 strobes during 250-bit hold", cnt, 250);
      hold_n = 1'b1;
      measure("R10 narrow after long hold", 12, 12);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule